// File: doc/BRIEF.md
# Radio Stream Command Register Decoder

This block is the register front end of one radio streaming channel. Software writes 32-bit words over a plain address/data/strobe bus into a register window. Within the slice that belongs to channel 0, it sets the packet size in words, the two halves of a 64-bit word budget and a stream command. Each accepted command becomes a one-cycle decode pulse. A start command takes a snapshot of the current parameters and starts a packet generator. The generator emits numbered words on a valid/ready stream and marks the final word of each packet.

In finite mode the generator cuts the word budget into full-size packets and, when the budget does not divide evenly, a shorter final packet. It then pulses a completion flag. In continuous mode it runs until a stop command arrives. A stop never truncates a packet that has already begun. A combinational read port returns the stored parameters and a fixed capability word that describes the sample format.

Top module: `radio_stream_ctrl`

## Requirements
- R1: After reset `busy`, `pkt_valid`, `cmd_err` and all decode pulses are low, and the parameter registers read back as zero.
- R2: A read at window base + 0x04 returns samples per cycle in bits 15:0 and sample width in bits 31:16. The packet size (slice offset 0x28), count low half (0x18) and count high half (0x1C) read back what was last written.
- R3: Writing one half of the 64-bit word count at offset 0x18 (bits 31:0) or 0x1C (bits 63:32) leaves the other half unchanged.
- R4: Writes outside channel 0's 0x80-byte slice starting at the window base (0x1000) change no register, produce no pulse and start no stream.
- R5: A write to slice offset 0x14 with value 0 pulses `go_stop`, 1 pulses `go_fin` and 2 pulses `go_cont`. The pulse lasts one cycle, in the cycle after the write, and never more than one of the three is high at once.
- R6: Bit 31 of the command word is ignored, so 0x80000001 acts as finite and 0x80000002 acts as continuous, starting at once.
- R7: Any other command value sets `cmd_err`, which stays set until reset. Such a value produces no pulse and does not change the stream.
- R8: A finite stream emits words numbered from 0 in packets of the programmed size, with a shorter last packet when needed and `pkt_last` on each packet's final word. `done` pulses for one cycle with `busy` low after exactly the programmed count has been accepted.
- R9: A packet size of 0 acts as 1. A finite start with a count of 0 pulses `done` in the next cycle, emits no word and never raises `busy`.
- R10: A continuous stream runs until a stop command. A stop that arrives mid-packet ends the stream after that packet's last word. A stop that arrives before the current packet's first word is accepted ends the stream in the next cycle.
- R11: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid`, `pkt_data` and `pkt_last` hold, unless a stop ends the stream at a packet boundary. No word is lost or repeated.
- R12: A start command while `busy` still pulses, but does not restart or change the running stream. Parameter writes during a stream do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 32 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| go_cont | output | 1 | Continuous-start decode pulse |
| go_fin | output | 1 | Finite-start decode pulse |
| go_stop | output | 1 | Stop decode pulse |
| cmd_err | output | 1 | Sticky invalid-command flag |
| busy | output | 1 | Stream active |
| done | output | 1 | Finite stream completion pulse |
| pkt_valid | output | 1 | Stream word valid |
| pkt_data | output | 32 | Word index within the stream |
| pkt_last | output | 1 | Final word of a packet |
| pkt_ready | input | 1 | Downstream ready |

## Verification
Each word carries its own index, so a counter that slips shows up at the ports at the next accepted word as a skipped or repeated value. A wrong remaining-count or in-packet counter shows up as a misplaced `pkt_last`, as a word total that differs from the budget, or as a missing or extra `done`, all at or before the stream's final word. A corrupted half-word register shows up right away on readback and, in the next finite run, as a wrong word total. A bad decode is visible one cycle after the write, through the pulses or `cmd_err`.

// File: rtl/radio_stream_ctrl.sv
module radio_stream_ctrl #(
  parameter logic [31:0] WIN_BASE        = 32'h0000_1000,
  parameter int          SLICE_BYTES     = 128,
  parameter int          MPP_W           = 16,
  parameter int          DATA_W          = 32,
  parameter logic [15:0] SAMPLES_PER_CYC = 16'd1,
  parameter logic [15:0] SAMPLE_BITS     = 16'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       rd_addr,
  output logic [31:0]       rd_data,
  output logic              go_cont,
  output logic              go_fin,
  output logic              go_stop,
  output logic              cmd_err,
  output logic              busy,
  output logic              done,
  output logic              pkt_valid,
  output logic [DATA_W-1:0] pkt_data,
  output logic              pkt_last,
  input  logic              pkt_ready
);
  localparam int OFF_W = $clog2(SLICE_BYTES);
  localparam logic [OFF_W-1:0] OFF_CAPS = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] OFF_CMD  = OFF_W'(8'h14);
  localparam logic [OFF_W-1:0] OFF_LO   = OFF_W'(8'h18);
  localparam logic [OFF_W-1:0] OFF_HI   = OFF_W'(8'h1C);
  localparam logic [OFF_W-1:0] OFF_MPP  = OFF_W'(8'h28);
  localparam logic [31:0] SPAN = 32'(SLICE_BYTES);

  logic [31:0]      wr_rel, rd_rel, cmd_val;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic             wr_ch0, rd_ch0, cmd_wr;
  logic             is_stop, is_fin, is_cont, is_bad;

  assign wr_rel  = wr_addr - WIN_BASE;
  assign rd_rel  = rd_addr - WIN_BASE;
  assign wr_ch0  = wr_rel < SPAN;
  assign rd_ch0  = rd_rel < SPAN;
  assign wr_off  = wr_rel[OFF_W-1:0];
  assign rd_off  = rd_rel[OFF_W-1:0];
  assign cmd_wr  = wr_en && wr_ch0 && (wr_off == OFF_CMD);
  assign cmd_val = {1'b0, wr_data[30:0]};
  assign is_stop = cmd_val == 32'd0;
  assign is_fin  = cmd_val == 32'd1;
  assign is_cont = cmd_val == 32'd2;
  assign is_bad  = !(is_stop || is_fin || is_cont);

  logic [MPP_W-1:0] mpp_q;
  logic [63:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mpp_q <= '0;
      cnt_q <= '0;
    end else if (wr_en && wr_ch0) begin
      if (wr_off == OFF_MPP) mpp_q <= wr_data[MPP_W-1:0];
      if (wr_off == OFF_LO)  cnt_q[31:0]  <= wr_data;
      if (wr_off == OFF_HI)  cnt_q[63:32] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ch0) begin
      case (rd_off)
        OFF_CAPS: rd_data = {SAMPLE_BITS, SAMPLES_PER_CYC};
        OFF_MPP:  rd_data = 32'(mpp_q);
        OFF_LO:   rd_data = cnt_q[31:0];
        OFF_HI:   rd_data = cnt_q[63:32];
        default:  rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_cont <= 1'b0;
      go_fin  <= 1'b0;
      go_stop <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      go_cont <= cmd_wr && is_cont;
      go_fin  <= cmd_wr && is_fin;
      go_stop <= cmd_wr && is_stop;
      cmd_err <= cmd_err || (cmd_wr && is_bad);
    end
  end

  logic              busy_q, cont_q, stop_pend_q, done_q;
  logic [63:0]       remain_q;
  logic [MPP_W-1:0]  size_q, left_q, eff_mpp;
  logic [DATA_W-1:0] idx_q;
  logic              fire, fin_end, last_w, at_boundary, stop_now, start_ok;

  assign eff_mpp     = (mpp_q == '0) ? MPP_W'(1) : mpp_q;
  assign fire        = busy_q && pkt_ready;
  assign fin_end     = !cont_q && (remain_q == 64'd1);
  assign last_w      = (left_q == MPP_W'(1)) || fin_end;
  assign at_boundary = left_q == size_q;
  assign stop_now    = cmd_wr && is_stop && busy_q;
  assign start_ok    = cmd_wr && (is_fin || is_cont) && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cont_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      done_q      <= 1'b0;
      remain_q    <= '0;
      size_q      <= MPP_W'(1);
      left_q      <= MPP_W'(1);
      idx_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        if (is_fin && cnt_q == 64'd0) begin
          done_q <= 1'b1;
        end else begin
          busy_q      <= 1'b1;
          cont_q      <= is_cont;
          stop_pend_q <= 1'b0;
          remain_q    <= cnt_q;
          size_q      <= eff_mpp;
          left_q      <= eff_mpp;
          idx_q       <= '0;
        end
      end else if (busy_q) begin
        if (fire) begin
          idx_q <= idx_q + 1'b1;
          if (!cont_q) remain_q <= remain_q - 64'd1;
          if (last_w) begin
            left_q <= size_q;
            if (fin_end) begin
              busy_q      <= 1'b0;
              done_q      <= 1'b1;
              stop_pend_q <= 1'b0;
            end else if (stop_pend_q || stop_now) begin
              busy_q      <= 1'b0;
              stop_pend_q <= 1'b0;
            end
          end else begin
            left_q <= left_q - 1'b1;
            if (stop_now) stop_pend_q <= 1'b1;
          end
        end else if (stop_now) begin
          if (at_boundary) begin
            busy_q      <= 1'b0;
            stop_pend_q <= 1'b0;
          end else begin
            stop_pend_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign pkt_valid = busy_q;
  assign pkt_data  = idx_q;
  assign pkt_last  = busy_q && last_w;
endmodule

// File: rtl/radio_stream_ctrl_chk.sv
module radio_stream_ctrl_chk #(
  parameter logic [31:0] WIN_BASE    = 32'h0000_1000,
  parameter int          SLICE_BYTES = 128,
  parameter int          DATA_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_addr,
  input logic              go_cont,
  input logic              go_fin,
  input logic              go_stop,
  input logic              cmd_err,
  input logic              busy,
  input logic              done,
  input logic              pkt_valid,
  input logic [DATA_W-1:0] pkt_data,
  input logic              pkt_last,
  input logic              pkt_ready
);
  logic outside;
  assign outside = (wr_addr - WIN_BASE) >= 32'(SLICE_BYTES);

  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_cont, go_fin, go_stop}));

  a_r4_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && outside) |=> !(go_cont || go_fin || go_stop));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pkt_valid));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=>
      ((pkt_valid && $stable(pkt_data) && $stable(pkt_last)) || go_stop));

  a_r12_start_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (go_cont || go_fin));
endmodule

bind radio_stream_ctrl radio_stream_ctrl_chk #(
  .WIN_BASE(WIN_BASE), .SLICE_BYTES(SLICE_BYTES), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .go_cont(go_cont), .go_fin(go_fin), .go_stop(go_stop), .cmd_err(cmd_err),
  .busy(busy), .done(done), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
  .pkt_last(pkt_last), .pkt_ready(pkt_ready)
);

// File: tb/radio_stream_ctrl_tb.sv
`timescale 1ns/1ps
module radio_stream_ctrl_tb_top;
  localparam time CYC = 10ns;
  localparam logic [31:0] B = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
  logic go_cont, go_fin, go_stop, cmd_err, busy, done;
  logic pkt_valid, pkt_last, pkt_ready = 1;
  logic [31:0] pkt_data;

  radio_stream_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .go_cont(go_cont), .go_fin(go_fin),
    .go_stop(go_stop), .cmd_err(cmd_err), .busy(busy), .done(done),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_ready(pkt_ready)
  );

  always #(CYC/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0;
  int n_cont = 0, n_fin = 0, n_stop = 0, n_done = 0;
  int mon_idx = 0, cur_len = 0, mon_err = 0;
  int exp_mpp = 1;
  longint exp_total = 0;
  bit exp_cont = 0;

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: pkt_ready = 1'b1;
      1: pkt_ready = ($urandom % 4) != 0;
      default: pkt_ready = 1'b0;
    endcase
  end

  function automatic bit want_last(int len, int idx, int mpp, longint tot, bit cont);
    return (len + 1 == mpp) || (!cont && longint'(idx + 1) == tot);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (go_cont) n_cont++;
      if (go_fin) n_fin++;
      if (go_stop) n_stop++;
      if (done) n_done++;
      if (pkt_valid && pkt_ready) begin
        if (pkt_data != 32'(mon_idx) ||
            pkt_last != want_last(cur_len, mon_idx, exp_mpp, exp_total, exp_cont))
          mon_err++;
        mon_idx++;
        cur_len = pkt_last ? 0 : cur_len + 1;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = 0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    settle();
  endtask

  task automatic arm(int mpp, longint tot, bit cont);
    exp_mpp = (mpp == 0) ? 1 : mpp;
    exp_total = tot; exp_cont = cont;
    mon_idx = 0; cur_len = 0; mon_err = 0;
  endtask

  task automatic run_finite(int mpp, int tot, int mode, string req);
    int d0;
    rdy_mode = mode;
    wr(B + 32'h18, 32'(tot));
    wr(B + 32'h1C, 32'd0);
    wr(B + 32'h28, 32'(mpp));
    arm(mpp, longint'(tot), 0);
    d0 = n_done;
    wr(B + 32'h14, 32'd1);
    wait_idle();
    check(mon_err == 0, req, mon_err, 0);
    check(mon_idx == tot, req, mon_idx, tot);
    check(n_done == d0 + 1, req, n_done - d0, 1);
  endtask

  initial begin
    #(CYC * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0, f0, s0, d0, seed;
    seed = $urandom(32'h1234_abcd);
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();

    // R1 reset state
    check(!busy && !pkt_valid && !cmd_err && !go_cont && !go_fin && !go_stop && !done,
          "R1", {busy, pkt_valid, cmd_err}, 0);
    rd(B + 32'h28, v); check(v == 0, "R1", v, 0);
    rd(B + 32'h18, v); check(v == 0, "R1", v, 0);

    // R2 capability word
    rd(B + 32'h04, v); check(v == 32'h0020_0001, "R2", v, 32'h0020_0001);

    // R3 half-word independence
    wr(B + 32'h18, 32'h1111_1111);
    wr(B + 32'h1C, 32'h2222_2222);
    rd(B + 32'h18, v); check(v == 32'h1111_1111, "R3", v, 32'h1111_1111);
    wr(B + 32'h18, 32'h3333_3333);
    rd(B + 32'h1C, v); check(v == 32'h2222_2222, "R3", v, 32'h2222_2222);
    wr(B + 32'h1C, 32'h4444_4444);
    rd(B + 32'h18, v); check(v == 32'h3333_3333, "R3", v, 32'h3333_3333);
    wr(B + 32'h28, 32'd9);
    rd(B + 32'h28, v); check(v == 9, "R2", v, 9);

    // R4 writes outside channel 0
    c0 = n_cont; f0 = n_fin; s0 = n_stop;
    wr(B + 32'h80 + 32'h28, 32'd77);
    wr(B + 32'h80 + 32'h14, 32'd2);
    wr(B + 32'h100 + 32'h14, 32'd1);
    wr(B - 32'h4, 32'd2);
    settle();
    rd(B + 32'h28, v); check(v == 9, "R4", v, 9);
    check(n_cont == c0 && n_fin == f0 && n_stop == s0 && !busy, "R4",
          n_cont + n_fin + n_stop, c0 + f0 + s0);

    // R7 invalid command
    c0 = n_cont; f0 = n_fin; s0 = n_stop;
    wr(B + 32'h14, 32'd5);
    settle();
    check(cmd_err && !busy, "R7", cmd_err, 1);
    check(n_cont == c0 && n_fin == f0 && n_stop == s0, "R7",
          n_cont + n_fin + n_stop, c0 + f0 + s0);

    // R5 R6 timed bit stripped, continuous start; R10 stop
    rdy_mode = 1;
    wr(B + 32'h28, 32'd4);
    arm(4, 0, 1);
    c0 = n_cont; f0 = n_fin;
    wr(B + 32'h14, 32'h8000_0002);
    check(busy, "R6", busy, 1);
    settle();
    check(n_cont == c0 + 1 && n_fin == f0, "R5", n_cont - c0, 1);
    repeat (13) @(negedge clk);
    s0 = n_stop;
    wr(B + 32'h14, 32'd0);
    wait_idle();
    check(n_stop == s0 + 1, "R5", n_stop - s0, 1);
    check(mon_err == 0 && (mon_idx % 4) == 0 && mon_idx > 0, "R10", mon_idx, 4);

    // R8 directed finite runs
    run_finite(4, 10, 0, "R8");
    run_finite(5, 5, 0, "R8");
    f0 = n_fin;
    wr(B + 32'h18, 32'd7); wr(B + 32'h1C, 0); wr(B + 32'h28, 32'd3);
    arm(3, 7, 0); d0 = n_done;
    wr(B + 32'h14, 32'h8000_0001);
    wait_idle();
    check(n_fin == f0 + 1 && mon_idx == 7 && n_done == d0 + 1, "R6", mon_idx, 7);

    // R9 size zero and count zero
    run_finite(0, 3, 1, "R9");
    wr(B + 32'h18, 32'd0);
    arm(2, 0, 0); d0 = n_done;
    wr(B + 32'h14, 32'd1);
    check(!busy, "R9", busy, 0);
    settle();
    check(n_done == d0 + 1 && mon_idx == 0, "R9", n_done - d0, 1);

    // R11 random sizes with backpressure
    for (int i = 0; i < 8; i++)
      run_finite(1 + int'($urandom % 8), 1 + int'($urandom % 40), 1, "R11");

    // R10 stop mid-packet with ready high
    rdy_mode = 0;
    wr(B + 32'h28, 32'd6);
    arm(6, 0, 1);
    wr(B + 32'h14, 32'd2);
    repeat (6) @(negedge clk);
    wr(B + 32'h14, 32'd0);
    wait_idle();
    check(mon_err == 0 && mon_idx == 12, "R10", mon_idx, 12);

    // R10 stop before first word while stalled
    rdy_mode = 2;
    wr(B + 32'h28, 32'd3);
    arm(3, 0, 1);
    wr(B + 32'h14, 32'd2);
    repeat (3) @(negedge clk);
    wr(B + 32'h14, 32'd0);
    #1;
    check(!busy && !pkt_valid && mon_idx == 0, "R10", mon_idx, 0);

    // R12 restart and parameter writes during a stream
    rdy_mode = 1;
    wr(B + 32'h18, 32'd9); wr(B + 32'h1C, 0); wr(B + 32'h28, 32'd3);
    arm(3, 9, 0); d0 = n_done; f0 = n_fin;
    wr(B + 32'h14, 32'd1);
    wr(B + 32'h28, 32'd7);
    wr(B + 32'h18, 32'd2);
    wr(B + 32'h14, 32'd1);
    wait_idle();
    check(mon_err == 0 && mon_idx == 9, "R12", mon_idx, 9);
    check(n_fin == f0 + 2 && n_done == d0 + 1, "R12", n_done - d0, 1);

    // R7 still sticky
    check(cmd_err, "R7", cmd_err, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule